// File: doc/BRIEF.md
# Guarded Clock Divider Control Register

This block holds one bus-addressed control register that sets the ratio between the incoming master clock and the system clock. The ratio is a power of two, from 1 to 256. The block does not produce a second clock. It produces a one-cycle clock-enable pulse at the divided rate, and logic in the master-clock domain uses that pulse to qualify its own updates. For a ratio of 1 the pulse stays high on every cycle.

A timed unlock sequence protects the divider selection from stray writes. Software first writes the exact unlock value. That opens a window of four clock cycles. During the window, one write with the top bit clear sets the new ratio. When the window ends or the ratio write lands, the window closes.

A strap input picks the ratio that the register loads at reset: divide-by-1 or divide-by-8. A new ratio takes effect only when the current divider period ends.

Top module: `clkdiv_guard`

## Requirements
- R1: A read at address 0x61 returns the window flag in bit 7, zeros in bits 6:4 and the ratio code in bits 3:0. Writes never change bits 6:4. A read at any other address returns 0x00.
- R2: Only a write of exactly 0x80 to address 0x61 opens the window while it is closed. This rules out any other value (for example 0x81) and any other address. Such writes leave the window flag at 0.
- R3: The window flag reads 1 during the four cycles after the unlock write. A ratio write in the fourth cycle after the unlock write is accepted. A ratio write in the fifth cycle is ignored, and the flag has cleared by then.
- R4: An unlock write made while the window is open neither restarts the four-cycle window nor closes it.
- R5: The ratio code changes only on a write to 0x61 with bit 7 at 0 while the window is open. That write loads bits 3:0 and closes the window. A write with bit 7 at 0 while the window is closed changes nothing.
- R6: After reset the ratio code is 0000 when strap_div8 is low and 0011 when it is high. After reset, any code can be written whatever the strap level.
- R7: Code n (0 to 8) divides by 2^n. Codes 9 to 15 divide by 256. The clk_en output pulses once per divided period.
- R8: With code 0000 the clk_en output is high on every cycle.
- R9: A new ratio is applied only at the next clk_en pulse. The period that is already running completes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_div8 | input | 1 | Selects divide-by-8 as the reset ratio when high |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Register bus write strobe, one write per cycle |
| bus_rdata | output | 8 | Register bus read data, combinational from bus_addr |
| clk_en | output | 1 | One-cycle enable at the divided rate |

## Verification
Two functions can act on the same clock edge.

The first pair is the window timeout and a ratio write. A ratio write placed in the last cycle of the window must win. The bench drives it exactly four cycles after the unlock write and expects the new code in the read-back. The same write one cycle later must leave the old code in place.

The second pair is a divider reload and a ratio change. The bench lines up an unlock write with the edge on which a clk_en pulse reloads the counter. The ratio write follows on the next edge. The bench then expects one full period at the old length before any period at the new one.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int SEL_W      = 4;
    localparam int WIN_CYC    = 4;
    localparam int TMR_W      = $clog2(WIN_CYC);
    localparam int LOCK_BIT   = 7;
    localparam logic [DATA_W-1:0] UNLOCK_PAT = 8'h80;
    localparam logic [SEL_W-1:0]  STRAP_SEL  = 4'd3;

    typedef struct packed {
        logic             en;
        logic [TMR_W-1:0] tmr;
        logic [SEL_W-1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
    import ckg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_div8,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic              en_o,
    output logic [SEL_W-1:0]  sel_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic  hit, unlock_wr, field_wr;

    always_comb begin
        hit       = bus_we && (bus_addr == REG_ADDR);
        unlock_wr = hit && (bus_wdata == UNLOCK_PAT);
        field_wr  = hit && !bus_wdata[LOCK_BIT];
        ctrl_d    = ctrl_q;
        if (ctrl_q.en) begin
            if (field_wr) begin
                ctrl_d.sel = bus_wdata[SEL_W-1:0];
                ctrl_d.en  = 1'b0;
                ctrl_d.tmr = '0;
            end else if (ctrl_q.tmr == '0) begin
                ctrl_d.en = 1'b0;
            end else begin
                ctrl_d.tmr = ctrl_q.tmr - 1'b1;
            end
        end else if (unlock_wr) begin
            ctrl_d.en  = 1'b1;
            ctrl_d.tmr = TMR_W'(WIN_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.en  <= 1'b0;
            ctrl_q.tmr <= '0;
            ctrl_q.sel <= strap_div8 ? STRAP_SEL : '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign en_o  = ctrl_q.en;
    assign sel_o = ctrl_q.sel;
endmodule

// File: rtl/ckg_divider.sv
module ckg_divider
    import ckg_pkg::*;
#(
    parameter int MAX_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int CNT_W = MAX_SHIFT;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t             div_d, div_q;
    logic [SEL_W-1:0] sh;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] reload;

    always_comb begin
        sh     = (sel_i > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel_i;
        span   = {{CNT_W{1'b0}}, 1'b1} << sh;
        reload = CNT_W'(span - 1'b1);
        div_d  = div_q;
        if (div_q.cnt == '0) begin
            div_d.cnt = reload;
        end else begin
            div_d.cnt = div_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q.cnt <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = (div_q.cnt == '0);
endmodule

// File: rtl/clkdiv_guard.sv
module clkdiv_guard
    import ckg_pkg::*;
#(
    parameter logic [7:0] REG_ADDR  = 8'h61,
    parameter int         MAX_SHIFT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_div8,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    output logic [7:0] bus_rdata,
    output logic       clk_en
);
    logic             ctl_en;
    logic [SEL_W-1:0] ctl_sel;

    ckg_ctrl #(.REG_ADDR(REG_ADDR)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_div8(strap_div8),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .en_o      (ctl_en),
        .sel_o     (ctl_sel)
    );

    ckg_divider #(.MAX_SHIFT(MAX_SHIFT)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (ctl_sel),
        .tick_o(clk_en)
    );

    assign bus_rdata = (bus_addr == REG_ADDR) ? {ctl_en, 3'b000, ctl_sel} : 8'h00;
endmodule

// File: rtl/ckg_checker.sv
module ckg_checker #(
    parameter logic [7:0] REG_ADDR = 8'h61
) (
    input logic       clk,
    input logic       rst_n,
    input logic       strap_div8,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_we,
    input logic [7:0] bus_rdata,
    input logic       clk_en,
    input logic       en,
    input logic [3:0] sel
);
    logic hit;
    assign hit = bus_we && (bus_addr == REG_ADDR);

    assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_ADDR) |-> (bus_rdata[6:4] == 3'b000));

    assert_exact_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(hit && (bus_wdata == 8'h80)));

    assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(en, 2) && $past(en, 3)) |=> !en);

    assert_sel_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |-> $past(en && hit && !bus_wdata[7]));

    assert_field_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && !bus_wdata[7]) |=> (!en && (sel == $past(bus_wdata[3:0]))));

    assert_reset_value_R6: assert property (@(posedge clk)
        $rose(rst_n) |-> (sel == ($past(strap_div8) ? 4'd3 : 4'd0)));

    assert_div1_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && (sel == 4'd0)) |=> clk_en);
endmodule

bind clkdiv_guard ckg_checker #(.REG_ADDR(REG_ADDR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_div8(strap_div8),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .clk_en    (clk_en),
    .en        (ctl_en),
    .sel       (ctl_sel)
);

// File: tb/clkdiv_guard_tb_top.sv
module clkdiv_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_div8 = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       clk_en;

    int checks = 0;
    int failures = 0;

    localparam logic [7:0] RA = 8'h61;
    localparam int NVEC = 10;
    // {code[3:0], expected factor[8:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {4'd1, 9'd2},  {4'd2, 9'd4},  {4'd0, 9'd1},   {4'd3, 9'd8},
        {4'd4, 9'd16}, {4'd5, 9'd32}, {4'd7, 9'd128}, {4'd8, 9'd256},
        {4'd9, 9'd256}, {4'd15, 9'd256}
    };

    always #5 clk = ~clk;

    clkdiv_guard dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_div8(strap_div8),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .clk_en    (clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!clk_en);
    endtask

    task automatic get_period(output int p);
        wait_pulse();
        wait_pulse();
        p = 0;
        do begin @(negedge clk); p++; end while (!clk_en);
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0;
        strap_div8 = s;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int p;

        // R6 reset with strap low, R8 divide by 1
        do_reset(1'b0);
        bus_read(RA, v);  check("R6 reset strap low", v, 8'h00);
        get_period(p);    check("R8 divide by 1 period", p, 1);
        bus_read(8'h60, v); check("R1 other address reads zero", v, 8'h00);

        // R7 table walk
        for (int i = 0; i < NVEC; i++) begin
            bus_write(RA, 8'h80);
            bus_write(RA, {4'b0000, VEC[i][12:9]});
            bus_read(RA, v);
            check("R5 code loaded", v, {4'b0000, VEC[i][12:9]});
            get_period(p);
            check("R7 divided period", p, int'(VEC[i][8:0]));
        end

        // R6 strap high, then any value writable
        do_reset(1'b1);
        bus_read(RA, v);  check("R6 reset strap high", v, 8'h03);
        get_period(p);    check("R6 strap period 8", p, 8);
        bus_write(RA, 8'h80); bus_write(RA, 8'h00);
        bus_read(RA, v);  check("R6 code 0 writable after strap", v, 8'h00);

        // R5 locked write ignored
        bus_write(RA, 8'h05);
        bus_read(RA, v);  check("R5 locked write ignored", v, 8'h00);

        // R2 non-exact unlock and wrong address
        bus_write(RA, 8'h81);
        bus_read(RA, v);  check("R2 0x81 does not unlock", v, 8'h00);
        bus_write(8'h62, 8'h80);
        bus_read(RA, v);  check("R2 wrong address does not unlock", v, 8'h00);

        // R1 flag readback
        bus_write(RA, 8'h80);
        bus_read(RA, v);  check("R1 window flag reads 1", v, 8'h80);
        idle(4);
        bus_read(RA, v);  check("R3 flag cleared after window", v, 8'h00);

        // R3 last accepted slot and first rejected slot
        bus_write(RA, 8'h80); idle(3); bus_write(RA, 8'h02);
        bus_read(RA, v);  check("R3 write in fourth cycle accepted", v, 8'h02);
        bus_write(RA, 8'h80); idle(4); bus_write(RA, 8'h04);
        bus_read(RA, v);  check("R3 write in fifth cycle ignored", v, 8'h02);

        // R4 re-unlock does not extend
        bus_write(RA, 8'h80); idle(1); bus_write(RA, 8'h80); idle(2);
        bus_write(RA, 8'h04);
        bus_read(RA, v);  check("R4 re-unlock does not extend", v, 8'h02);
        idle(4);
        // R4 re-unlock does not clear
        bus_write(RA, 8'h80); bus_write(RA, 8'h80); idle(2);
        bus_write(RA, 8'h04);
        bus_read(RA, v);  check("R4 re-unlock does not clear", v, 8'h04);

        // R1 bits 6:4 ignore writes
        bus_write(RA, 8'h80); bus_write(RA, 8'h71);
        bus_read(RA, v);  check("R1 bits 6:4 stay zero", v, 8'h01);

        // R9 change applied at period end: move from 16 to 2
        bus_write(RA, 8'h80); bus_write(RA, 8'h04);
        wait_pulse(); wait_pulse();
        bus_write(RA, 8'h80); bus_write(RA, 8'h01);
        p = 2;
        while (!clk_en) begin @(negedge clk); p++; end
        check("R9 running period keeps old length", p, 16);
        p = 0;
        do begin @(negedge clk); p++; end while (!clk_en);
        check("R9 next period uses new length", p, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule